// File: doc/BRIEF.md
# Morse Symbol Pulse Generator

This block turns a start level into one Morse character made of three tone bursts on a single buzzer line. The burst length is a parameter, so the same design yields a dot (short burst) or a dash (long burst). The gap after each burst is a separate parameter. When the sixth and last phase has run out, the block answers with a done pulse that lasts one clock.

Timing comes from a millisecond tick divider and a millisecond counter. The tick divider runs only while the current phase is counting. The millisecond counter compares its value against a per-phase target that is reloaded at the start of every phase. A controller walks a step index through six timed phases and two handshake steps. It talks to the timing datapath through a small bundle of strobes.

The caller raises the start level and keeps it high until done has come and gone. Lowering start freezes the whole block in place. Raising it again resumes the sequence from the same point.

Top module: `morse_symbol_gen`

## Requirements
- R1: While the active-low asynchronous reset is asserted, the tone output and the done output are both 0.
- R2: While the start input is low after reset, or after a finished character, the tone and done outputs stay 0.
- R3: Each burst phase (steps 0, 2 and 4) drives tone to 1 for exactly ON_MS*(CLK_HZ/1000)+2 clock cycles. The count starts from the first clock edge that sees start high.
- R4: Each gap phase (steps 1, 3 and 5) drives tone to 0 for exactly OFF_MS*(CLK_HZ/1000)+2 clock cycles.
- R5: One character is exactly three bursts, each followed by a gap, in the order high, low, high, low, high, low.
- R6: The clock edge that ends the last gap is followed by an edge that raises done for exactly one cycle, with tone at 0. Done then falls on the next edge while start stays high.
- R7: A low start input freezes the tone level, the step and both counters. Each cycle spent low lengthens the current phase by exactly one cycle.
- R8: Two instances that differ only in ON_MS produce the same sequence. The only difference is the length of their bursts.
- R9: The millisecond counter never exceeds its target. The tick divider is held at zero whenever a phase is not counting. The target resets to a non-zero value, so no phase can end before its first load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, CLK_HZ hertz |
| rstN | input | 1 | Asynchronous reset, active low |
| startLvl | input | 1 | Run level; high lets the sequence advance |
| toneOut | output | 1 | Buzzer drive, 1 during a burst |
| doneOut | output | 1 | One-cycle pulse after the last gap |

## Verification
The assertions assume that start stays high from the first burst until done has fallen. Only the pause test lowers it early, and it does so only in the middle of a phase. They also assume that reset is released while start is low. The stimulus changes start and reset only on falling clock edges. Start is lowered in the cycle after done falls, and start stays low around every reset pulse, so the done handshake never waits on a low start.

// File: rtl/morse_symbol_pkg.sv
package morse_symbol_pkg;

  // Strobes from the sequencer to the timing datapath
  typedef struct packed {
    logic countEn;  // phase is counting milliseconds
    logic freeze;   // start is low: hold every timing register
    logic loadOn;   // load the burst duration as target
    logic loadOff;  // load the gap duration as target
  } ctrlStrb_t;

  localparam int unsigned STEP_W    = 3;
  localparam int unsigned LAST_TIMED = 5;

endpackage

// File: rtl/morse_symbol_dp.sv
module morse_symbol_dp
  import morse_symbol_pkg::*;
#(
  parameter int unsigned CLK_HZ = 50_000_000,
  parameter int unsigned ON_MS  = 100,
  parameter int unsigned OFF_MS = 50
) (
  input  logic      clk,
  input  logic      rstN,
  input  ctrlStrb_t strb,
  output logic      stepMatch
);

  localparam int unsigned TICK_CYC = (CLK_HZ / 1000 > 1) ? CLK_HZ / 1000 : 2;
  localparam int unsigned TICK_W   = $clog2(TICK_CYC);
  localparam int unsigned MS_MAX   = (ON_MS > OFF_MS) ? ON_MS : OFF_MS;
  localparam int unsigned MS_W     = $clog2(MS_MAX + 1);

  logic [TICK_W-1:0] tickCnt;
  logic [MS_W-1:0]   msCnt;
  logic [MS_W-1:0]   target;
  logic              tickPulse;

  assign tickPulse = strb.countEn && !strb.freeze &&
                     (tickCnt == TICK_W'(TICK_CYC - 1));
  assign stepMatch = (msCnt == target);

  // Millisecond tick divider, gated by the count enable
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt <= '0;
    end else if (!strb.freeze) begin
      if (!strb.countEn || tickPulse) tickCnt <= '0;
      else                            tickCnt <= tickCnt + 1'b1;
    end
  end

  // Millisecond counter: wraps to zero in the cycle it equals the target
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      msCnt <= '0;
    end else if (!strb.freeze) begin
      if (stepMatch)      msCnt <= '0;
      else if (tickPulse) msCnt <= msCnt + 1'b1;
    end
  end

  // Per-phase target, reset to all ones so nothing matches before a load
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      target <= '1;
    end else if (strb.loadOn) begin
      target <= MS_W'(ON_MS);
    end else if (strb.loadOff) begin
      target <= MS_W'(OFF_MS);
    end
  end

  AST_MS_WITHIN_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    msCnt <= target); // R9
  AST_TICK_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.countEn && !strb.freeze) |=> (tickCnt == '0)); // R9
  AST_FREEZE_HOLDS_MS: assert property (@(posedge clk) disable iff (!rstN)
    strb.freeze |=> $stable(msCnt) && $stable(tickCnt)); // R7

endmodule

// File: rtl/morse_symbol_ctrl.sv
module morse_symbol_ctrl
  import morse_symbol_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startLvl,
  input  logic      stepMatch,
  output ctrlStrb_t strb,
  output logic      toneOut,
  output logic      doneOut
);

  logic [STEP_W-1:0] stepIdx;
  logic              countEnQ;
  logic              timedStep;
  logic              firstPass;

  assign timedStep = (stepIdx <= STEP_W'(LAST_TIMED));
  assign firstPass = startLvl && timedStep && !stepMatch;

  always_comb begin
    strb.countEn = countEnQ;
    strb.freeze  = !startLvl;
    strb.loadOn  = firstPass && !stepIdx[0];
    strb.loadOff = firstPass &&  stepIdx[0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stepIdx  <= '0;
      countEnQ <= 1'b0;
      toneOut  <= 1'b0;
      doneOut  <= 1'b0;
    end else if (startLvl) begin
      if (timedStep) begin
        if (stepMatch) begin
          countEnQ <= 1'b0;
          stepIdx  <= stepIdx + 1'b1;
        end else begin
          countEnQ <= 1'b1;
          toneOut  <= ~stepIdx[0];
        end
      end else if (stepIdx == STEP_W'(LAST_TIMED + 1)) begin
        doneOut <= 1'b1;
        stepIdx <= stepIdx + 1'b1;
      end else begin
        doneOut <= 1'b0;
        stepIdx <= '0;
      end
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (doneOut && startLvl) |=> !doneOut); // R6
  AST_DONE_TONE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |-> !toneOut); // R6
  AST_PAUSE_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    !startLvl |=> $stable(toneOut) && $stable(stepIdx) && $stable(doneOut)); // R7
  AST_NO_END_BEFORE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (stepIdx == '0 && !countEnQ) |-> !stepMatch); // R9

endmodule

// File: rtl/morse_symbol_gen.sv
module morse_symbol_gen
  import morse_symbol_pkg::*;
#(
  parameter int unsigned CLK_HZ = 50_000_000,
  parameter int unsigned ON_MS  = 100,
  parameter int unsigned OFF_MS = 50
) (
  input  logic clk,
  input  logic rstN,
  input  logic startLvl,
  output logic toneOut,
  output logic doneOut
);

  ctrlStrb_t strb;
  logic      stepMatch;

  morse_symbol_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .startLvl  (startLvl),
    .stepMatch (stepMatch),
    .strb      (strb),
    .toneOut   (toneOut),
    .doneOut   (doneOut)
  );

  morse_symbol_dp #(
    .CLK_HZ (CLK_HZ),
    .ON_MS  (ON_MS),
    .OFF_MS (OFF_MS)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .stepMatch (stepMatch)
  );

endmodule

// File: tb/tb_morse_symbol_gen.sv
module tb_morse_symbol_gen;

  localparam int CLK_PERIOD = 10;
  localparam int T_HZ   = 8000;
  localparam int TICK   = T_HZ / 1000;
  localparam int DOT_ON = 3;
  localparam int DSH_ON = 6;
  localparam int GAP_MS = 2;
  localparam int LEN_DOT = DOT_ON * TICK + 2;
  localparam int LEN_DSH = DSH_ON * TICK + 2;
  localparam int LEN_GAP = GAP_MS * TICK + 2;

  typedef struct packed { logic lvl; logic isOn; } phase_t;
  localparam phase_t PHASES [6] = '{
    '{1'b1, 1'b1}, '{1'b0, 1'b0}, '{1'b1, 1'b1},
    '{1'b0, 1'b0}, '{1'b1, 1'b1}, '{1'b0, 1'b0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startDot = 1'b0;
  logic startDsh = 1'b0;
  logic toneDot, doneDot, toneDsh, doneDsh;
  bit   useDash = 1'b0;

  int nChecks = 0;
  int nFails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  morse_symbol_gen #(.CLK_HZ(T_HZ), .ON_MS(DOT_ON), .OFF_MS(GAP_MS)) dut (
    .clk(clk), .rstN(rstN), .startLvl(startDot), .toneOut(toneDot), .doneOut(doneDot));

  morse_symbol_gen #(.CLK_HZ(T_HZ), .ON_MS(DSH_ON), .OFF_MS(GAP_MS)) dutLong (
    .clk(clk), .rstN(rstN), .startLvl(startDsh), .toneOut(toneDsh), .doneOut(doneDsh));

  wire curTone = useDash ? toneDsh : toneDot;
  wire curDone = useDash ? doneDsh : doneDot;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setStart(input bit v);
    if (useDash) startDsh = v; else startDot = v;
  endtask

  // One full character; pauseLen cycles of low start inside the first burst
  task automatic runSymbol(input bit dash, input int pauseLen, input string tag);
    useDash = dash;
    @(negedge clk);
    setStart(1'b1);
    for (int p = 0; p < 6; p++) begin
      int len;
      int badCnt;
      len = PHASES[p].isOn ? (dash ? LEN_DSH : LEN_DOT) : LEN_GAP;
      if (p == 0) len += pauseLen;
      badCnt = 0;
      for (int k = 0; k < len; k++) begin
        @(negedge clk);
        if (curTone !== PHASES[p].lvl || curDone !== 1'b0) badCnt++;
        if (p == 0 && pauseLen > 0 && k == 4) setStart(1'b0);
        if (p == 0 && pauseLen > 0 && k == 4 + pauseLen) setStart(1'b1);
      end
      chk(badCnt == 0, PHASES[p].isOn ? {tag, " R3 R5 burst length"} : {tag, " R4 R5 gap length"},
          badCnt, 0);
    end
    @(negedge clk);
    chk(curDone === 1'b1 && curTone === 1'b0, {tag, " R6 done raised"}, curDone, 1);
    @(negedge clk);
    chk(curDone === 1'b0, {tag, " R6 done one cycle"}, curDone, 0);
    setStart(1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nFails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    int badCnt;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(toneDot === 1'b0 && doneDot === 1'b0, "R1 reset outputs dot", toneDot, 0);
    chk(toneDsh === 1'b0 && doneDsh === 1'b0, "R1 reset outputs dash", toneDsh, 0);
    rstN = 1'b1;

    // R2: idle while start low
    badCnt = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (toneDot !== 1'b0 || doneDot !== 1'b0) badCnt++;
    end
    chk(badCnt == 0, "R2 idle with start low", badCnt, 0);

    // Table-driven dot character, R3 R4 R5 R6
    runSymbol(1'b0, 0, "dot");

    // R2: after a character, nothing happens with start low
    badCnt = 0;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (toneDot !== 1'b0 || doneDot !== 1'b0) badCnt++;
    end
    chk(badCnt == 0, "R2 idle after done", badCnt, 0);

    // R8: dash variant, dot instance stays silent
    badCnt = 0;
    fork
      runSymbol(1'b1, 0, "dash R8");
      for (int k = 0; k < 3 * (LEN_DSH + LEN_GAP); k++) begin
        @(negedge clk);
        if (toneDot !== 1'b0) badCnt++;
      end
    join
    chk(badCnt == 0, "R2 dot instance untouched during dash", badCnt, 0);

    // R7: pause of 13 cycles inside the first burst
    runSymbol(1'b0, 13, "pause R7");

    // R1: asynchronous reset mid-character, then a clean run
    useDash = 1'b0;
    @(negedge clk);
    startDot = 1'b1;
    repeat (10) @(negedge clk);
    chk(toneDot === 1'b1, "R3 burst under way before reset", toneDot, 1);
    startDot = 1'b0;
    #1 rstN = 1'b0;
    #1;
    chk(toneDot === 1'b0 && doneDot === 1'b0, "R1 async reset clears outputs", toneDot, 0);
    @(negedge clk);
    rstN = 1'b1;
    runSymbol(1'b0, 0, "after reset R1");

    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule